// File: doc/BRIEF.md
# Dual-Register Data Rate Selector

This block holds the two-bit data-rate code of a floppy disk controller. Host software may set the code through either of two write addresses: the configuration control register or the data rate select register. Both use the same encoding in bits 1:0. The two registers share a single rate field, so the register written most recently decides the active rate. The active code drives two rate pins directly.

From the active code the block derives a clock-enable tick. The tick is one master-clock cycle wide and repeats once per bit cell. It paces the microengine and the data separator at the chosen rate. Each write to the rate field restarts the tick divider from zero, so no early or short tick follows a rate change.

The upper six bits of the data rate select register go out unchanged for other blocks to use. These bits carry the low-power request and the precompensation setting. A read at the configuration control address returns status data supplied from outside the block.

Top module: `data_rate_select`

## Requirements
- R1: After synchronous reset the rate code and `drate` are 00, `dsr_bits` is 0, and the first `cell_tick` comes exactly DIV(00) cycles after the last reset edge.
- R2: A write to address 0x3F7 (configuration control) loads `wr_data[1:0]` into the rate code. `drate` shows it from the cycle after the write edge, and `wr_data[7:2]` of that write has no effect.
- R3: A write to address 0x3F4 (data rate select) loads `wr_data[1:0]` into the rate code with the same encoding as R2. It also loads `wr_data[7:2]` into `dsr_bits[5:0]`, so the low-power request (written bit 6) appears on `dsr_bits[4]`. A configuration control write leaves `dsr_bits` unchanged.
- R4: The active code is the one from the most recent write to either register. A write to one register overrides an earlier write to the other.
- R5: Rate code to divide ratio, with master clock `CLK_KHZ` = 24000: 00 (500 kbps) gives 48, 01 (300 kbps) gives 80, 10 (250 kbps) gives 96, and 11 (1 Mbps) gives 24. `cell_tick` is high for one cycle, once every DIV cycles.
- R6: Every write to either rate register restarts the divider. The next `cell_tick` comes exactly DIV(new code) cycles after the write edge, and no tick comes before it, even if the old count was about to expire.
- R7: A write to any other address changes neither `drate`, `dsr_bits` nor the tick cadence.
- R8: `rd_data` equals `status_in` while `addr` is 0x3F7, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 10 | Host register address |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | 8 | Host write data |
| status_in | input | 8 | Status byte returned at the configuration control address |
| rd_data | output | 8 | Host read data |
| drate | output | 2 | Active rate code pins |
| cell_tick | output | 1 | One-cycle clock enable per bit cell |
| dsr_bits | output | 6 | Raw bits 7:2 of the last data rate select write |

## Verification
On every cycle the assertions check these properties: each rate write lands in the code on the next cycle, writes to foreign addresses leave the code stable, the upper bits follow only data rate select writes, a tick never lasts two cycles, and no tick follows directly after a restart. The exact spacing between ticks for each of the four codes can only be shown by the bench's scenarios. The same holds for the restart that suppresses a pending tick, for last-write-wins ordering across the two registers, and for the read mux. The bench measures tick-to-tick gaps against a queue of expected intervals.

// File: rtl/rate_sel_pkg.sv
package rate_sel_pkg;

    typedef enum logic [1:0] {
        RATE_500K = 2'b00,
        RATE_300K = 2'b01,
        RATE_250K = 2'b10,
        RATE_1M   = 2'b11
    } rate_code_e;

    typedef struct packed {
        logic       load;
        rate_code_e code;
    } rate_upd_t;

    function automatic int unsigned rate_kbps(rate_code_e c);
        case (c)
            RATE_500K: return 500;
            RATE_300K: return 300;
            RATE_250K: return 250;
            default:   return 1000;
        endcase
    endfunction

    function automatic int unsigned cell_div(int unsigned clk_khz, rate_code_e c);
        return clk_khz / rate_kbps(c);
    endfunction

endpackage

// File: rtl/rate_reg_file.sv
module rate_reg_file
    import rate_sel_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 8,
    parameter logic [ADDR_W-1:0] CCR_ADDR = 10'h3F7,
    parameter logic [ADDR_W-1:0] DSR_ADDR = 10'h3F4,
    localparam int UPPER_W = DATA_W - 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output rate_code_e         rate_q,
    output rate_upd_t          upd,
    output logic [UPPER_W-1:0] upper_q
);

    logic hit_ccr, hit_dsr;

    always_comb begin
        hit_ccr   = wr_en && (addr == CCR_ADDR);
        hit_dsr   = wr_en && (addr == DSR_ADDR);
        upd.load  = hit_ccr || hit_dsr;
        upd.code  = rate_code_e'(wr_data[1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q  <= RATE_500K;
            upper_q <= '0;
        end else begin
            if (upd.load) rate_q <= upd.code;
            if (hit_dsr)  upper_q <= wr_data[DATA_W-1:2];
        end
    end

    // R2
    ccr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == CCR_ADDR) |=> (rate_q == $past(wr_data[1:0])));

    // R3
    dsr_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == DSR_ADDR) |=> (upper_q == $past(wr_data[DATA_W-1:2])));

    // R7
    other_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || (addr != CCR_ADDR && addr != DSR_ADDR)) |=> ($stable(rate_q) && $stable(upper_q)));

endmodule

// File: rtl/cell_divider.sv
module cell_divider
    import rate_sel_pkg::*;
#(
    parameter int CLK_KHZ = 24000,
    localparam int MAX_DIV = CLK_KHZ / 250,
    localparam int CNT_W   = $clog2(MAX_DIV + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  rate_code_e rate_q,
    input  rate_upd_t  upd,
    output logic       tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt = CNT_W'(cell_div(CLK_KHZ, rate_q) - 1);
    end

    always_ff @(posedge clk) begin
        if (rst || upd.load) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= last_cnt) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        upd.load |=> !tick);

    // R5
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/data_rate_select.sv
module data_rate_select
    import rate_sel_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 8,
    parameter int CLK_KHZ = 24000,
    parameter logic [ADDR_W-1:0] CCR_ADDR = 10'h3F7,
    parameter logic [ADDR_W-1:0] DSR_ADDR = 10'h3F4,
    localparam int UPPER_W = DATA_W - 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [DATA_W-1:0]  status_in,
    output logic [DATA_W-1:0]  rd_data,
    output logic [1:0]         drate,
    output logic               cell_tick,
    output logic [UPPER_W-1:0] dsr_bits
);

    rate_code_e rate_q;
    rate_upd_t  upd;

    rate_reg_file #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CCR_ADDR(CCR_ADDR), .DSR_ADDR(DSR_ADDR)
    ) i_regs (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rate_q(rate_q), .upd(upd), .upper_q(dsr_bits)
    );

    cell_divider #(.CLK_KHZ(CLK_KHZ)) i_div (
        .clk(clk), .rst(rst), .rate_q(rate_q), .upd(upd), .tick(cell_tick)
    );

    always_comb begin
        drate   = rate_q;
        rd_data = (addr == CCR_ADDR) ? status_in : '0;
    end

    // R1
    reset_rate_chk: assert property (@(posedge clk)
        $past(rst) |-> (drate == 2'b00 && !cell_tick));

endmodule

// File: tb/test_data_rate_select.sv
module test_data_rate_select;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] status_in = 8'hA5;
    logic [7:0] rd_data;
    logic [1:0] drate;
    logic       cell_tick;
    logic [5:0] dsr_bits;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int last_ref = 0;
    int gap_q[$];
    string tag_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    data_rate_select i_data_rate_select (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .status_in(status_in), .rd_data(rd_data), .drate(drate),
        .cell_tick(cell_tick), .dsr_bits(dsr_bits)
    );

    function automatic int exp_div(logic [1:0] c);
        case (c)
            2'b00: return 48;
            2'b01: return 80;
            2'b10: return 96;
            default: return 24;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: pops expected gaps as ticks arrive
    always @(negedge clk) begin
        if (cell_tick) begin
            if (gap_q.size() > 0) begin
                check(tag_q.pop_front(), cyc - last_ref, gap_q.pop_front());
            end
            last_ref = cyc;
        end
    end

    task automatic expect_gaps(string req, int g, int n);
        for (int i = 0; i < n; i++) begin
            gap_q.push_back(g);
            tag_q.push_back(req);
        end
    endtask

    task automatic drain(string req);
        int t = 0;
        while (gap_q.size() > 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (gap_q.size() > 0) begin
            check({req, " tick missing"}, gap_q.size(), 0);
            gap_q.delete();
            tag_q.delete();
        end
    endtask

    // driver: one-cycle write; restart marks the write edge as reference
    task automatic write_reg(logic [9:0] a, logic [7:0] d, bit restart);
        @(posedge clk); #2;
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #2;
        wr_en = 1'b0; addr = 10'h000;
        if (restart) last_ref = cyc;
    endtask

    initial begin
        #1500000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        last_ref = cyc;
        expect_gaps("R1 first tick after reset", exp_div(2'b00), 1);
        expect_gaps("R5 500k period", exp_div(2'b00), 2);
        check("R1 reset drate", drate, 0);
        check("R1 reset dsr_bits", dsr_bits, 0);
        drain("R1");

        // R2: config control write, upper bits ignored
        write_reg(10'h3F7, 8'hFF, 1'b1);
        check("R2 ccr drate", drate, 3);
        check("R2 ccr leaves dsr_bits", dsr_bits, 0);
        expect_gaps("R5 1M period", exp_div(2'b11), 3);
        drain("R2");

        // R3: data rate select write with upper bits, bit 6 set
        write_reg(10'h3F4, 8'b0101_0110, 1'b1);
        check("R3 dsr drate", drate, 2);
        check("R3 dsr upper bits", dsr_bits, 6'b010101);
        check("R3 low power bit", dsr_bits[4], 1);
        expect_gaps("R5 250k period", exp_div(2'b10), 2);
        drain("R3");

        // R4: ccr overrides dsr; dsr bits kept
        write_reg(10'h3F7, 8'h01, 1'b1);
        check("R4 ccr overrides dsr", drate, 1);
        check("R4 dsr_bits kept", dsr_bits, 6'b010101);
        expect_gaps("R5 300k period", exp_div(2'b01), 2);
        drain("R4");

        // R4: dsr overrides ccr
        write_reg(10'h3F4, 8'h03, 1'b1);
        check("R4 dsr overrides ccr", drate, 3);
        check("R3 dsr bits cleared", dsr_bits, 0);
        expect_gaps("R4 1M after dsr", exp_div(2'b11), 1);
        drain("R4b");

        // R7: other addresses ignored, cadence unchanged
        write_reg(10'h3F5, 8'hFE, 1'b0);
        write_reg(10'h0F7, 8'hFE, 1'b0);
        check("R7 drate unchanged", drate, 3);
        check("R7 dsr_bits unchanged", dsr_bits, 0);
        expect_gaps("R7 cadence unchanged", exp_div(2'b11), 3);
        drain("R7");

        // R6: restart just before a pending tick, same code
        write_reg(10'h3F7, 8'h00, 1'b1);
        expect_gaps("R6 setup", exp_div(2'b00), 1);
        drain("R6a");
        repeat (44) @(posedge clk);
        write_reg(10'h3F4, 8'h00, 1'b1);
        expect_gaps("R6 restart gap", exp_div(2'b00), 2);
        drain("R6b");

        // R8: read mux
        @(negedge clk);
        addr = 10'h3F7;
        #1 check("R8 read at ccr", rd_data, 8'hA5);
        status_in = 8'h3C;
        #1 check("R8 read follows status", rd_data, 8'h3C);
        addr = 10'h3F4;
        #1 check("R8 read elsewhere", rd_data, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule